// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-word memory burst. A load strobe captures a full external base address. After that, each clock edge with the advance input low moves the burst one beat along. The upper address bits always keep the captured value. Only the two lowest bits walk through the burst. The memory array, chip-select decoding and data paths sit in neighbouring logic.

The beat position is held in a four-state machine:

| State | Meaning |
|-------|---------|
| BEAT0 | the start beat, entered on reset and on every load |
| BEAT1 | second beat |
| BEAT2 | third beat |
| BEAT3 | fourth beat |

The machine has three kinds of transition:

- **restart**: any state goes to BEAT0 when a load occurs.
- **step**: BEATn goes to BEATn+1, and BEAT3 goes back to BEAT0, when advance is low and there is no load.
- **hold**: the state stays the same when advance is high and there is no load.

A mode input picks how the beat number combines with the captured low bits. In interleaved mode the beat number is XORed into them. In linear mode it is added to them modulo four. The mode is expected to stay constant while the block operates.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `addr_o` is all zeros and the sequencer is in BEAT0.
- R2: After a clock edge with a load strobe high, `addr_o` equals the `addr_i` value sampled on that edge.
- R3: On an edge with no load, bits `addr_o[AW-1:2]` keep their previous value.
- R4: With `mode_i`=1 (interleaved), `addr_o[1:0]` equals the captured base low bits XOR n, where n is the number of steps since the load, taken modulo 4. Starting from 01, the sequence is 01, 00, 11, 10.
- R5: With `mode_i`=0 (linear), `addr_o[1:0]` equals (captured base low bits + n) mod 4. Starting from 10, the sequence is 10, 11, 00, 01.
- R6: An edge with `adv_n_i`=1 and no load leaves `addr_o` unchanged.
- R7: After four steps from a load, `addr_o` is again the captured start address.
- R8: A load on an edge where `adv_n_i`=0 takes priority over the step. The count restarts at beat zero with the new base.
- R9: `ld_ext_i` and `ld_alt_i` load in the same way, and either one alone is enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_ext_i | input | 1 | Load strobe, active high |
| ld_alt_i | input | 1 | Second load strobe, active high, equivalent to the first |
| adv_n_i | input | 1 | Advance, active low |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | AW | External base address |
| addr_o | output | AW | Current burst address |

## Verification
Every result appears exactly one clock edge after the stimulus that causes it. The captured base and the beat state are registers, and the low-bit mapping between them and `addr_o` is combinational. The bench therefore drives inputs on the falling edge and compares `addr_o` one time unit after the following rising edge. Its model updates its own base and count at that same edge. The sweep covers both modes and all four start values, and mixes steps, holds and wrap-arounds. It also covers loads that collide with an advance, loads from each strobe separately, and loads from both strobes together.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_e;

    localparam int unsigned LOW_BITS = 2;

    // Interleaved order: the beat number is XORed into the start bits.
    function automatic logic [LOW_BITS-1:0] map_interleaved(
        input logic [LOW_BITS-1:0] start,
        input beat_e               beat
    );
        return start ^ LOW_BITS'(beat);
    endfunction

    // Linear order: the beat number is added to the start bits, wrapping at four.
    function automatic logic [LOW_BITS-1:0] map_linear(
        input logic [LOW_BITS-1:0] start,
        input beat_e               beat
    );
        return start + LOW_BITS'(beat);
    endfunction

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart_i,
    input  logic  adv_n_i,
    output beat_e beat_o
);

    beat_e beat_q, beat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beat_q <= BEAT0;
        else        beat_q <= beat_d;
    end

    always_comb begin
        beat_d = beat_q;
        if (restart_i) begin
            beat_d = BEAT0;
        end else if (!adv_n_i) begin
            unique case (beat_q)
                BEAT0: beat_d = BEAT1;
                BEAT1: beat_d = BEAT2;
                BEAT2: beat_d = BEAT3;
                BEAT3: beat_d = BEAT0;
                default: beat_d = BEAT0;
            endcase
        end
    end

    assign beat_o = beat_q;

    // R8: a load always lands in BEAT0, even when an advance comes on the same edge
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (beat_q == BEAT0));

    // R6: a hold edge keeps the beat where it is
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && adv_n_i) |=> $stable(beat_q));

    // R7: every step moves one beat on, so four steps return to the start beat
    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !adv_n_i) |=> (2'(beat_q) == 2'($past(beat_q) + 2'd1)));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] base_o
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         base_q <= '0;
        else if (capture_i) base_q <= addr_i;
    end

    assign base_o = base_q;

    // R2: a capture edge stores exactly the address that was presented
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (base_q == $past(addr_i)));

endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
    import burst_pkg::*;
(
    input  logic [LOW_BITS-1:0] start_i,
    input  beat_e               beat_i,
    input  logic                mode_i,
    output logic [LOW_BITS-1:0] low_o
);

    logic [LOW_BITS-1:0] low_ilv;
    logic [LOW_BITS-1:0] low_lin;

    always_comb begin
        low_ilv = map_interleaved(start_i, beat_i);
        low_lin = map_linear(start_i, beat_i);
        low_o   = mode_i ? low_ilv : low_lin;
    end

    // R4/R5: at the start beat both orders give back the start bits
    always_comb begin
        if (beat_i == BEAT0) begin
            assert_start_R4: assert (low_o == start_i);
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_ext_i,
    input  logic          ld_alt_i,
    input  logic          adv_n_i,
    input  logic          mode_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);

    localparam int unsigned HI_W = AW - LOW_BITS;

    logic                load;
    logic [AW-1:0]       base;
    beat_e               beat;
    logic [LOW_BITS-1:0] low;

    // R9: the two strobes are interchangeable
    assign load = ld_ext_i | ld_alt_i;

    burst_base_reg #(.AW(AW)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (load),
        .addr_i    (addr_i),
        .base_o    (base)
    );

    burst_beat_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .adv_n_i   (adv_n_i),
        .beat_o    (beat)
    );

    burst_low_map u_map (
        .start_i (base[LOW_BITS-1:0]),
        .beat_i  (beat),
        .mode_i  (mode_i),
        .low_o   (low)
    );

    assign addr_o = {base[AW-1:LOW_BITS], low};

    // R3: the upper bits never move during a burst
    assert_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_o[AW-1:LOW_BITS]));

    // R2: the edge after a load presents the loaded address unchanged
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_o == $past(addr_i)));

    // R6: a hold edge leaves the address alone (the mode is static)
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n_i && $stable(mode_i)) |=> $stable(addr_o));

    initial begin
        assert_width_R3: assert (HI_W >= 1);
    end

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_ext_i = 1'b0;
    logic          ld_alt_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;

    always #5 clk = ~clk;

    burst_addr_gen #(.AW(AW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_ext_i (ld_ext_i),
        .ld_alt_i (ld_alt_i),
        .adv_n_i  (adv_n_i),
        .mode_i   (mode_i),
        .addr_i   (addr_i),
        .addr_o   (addr_o)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] lo;
        lo = mode_i ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_vec++;
        if (addr_o !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // One cycle: drive on the falling edge, let the model and the DUT take the
    // rising edge, then compare one time unit later.
    task automatic cycle(input logic le, input logic la, input logic an,
                         input logic [AW-1:0] a, input string req);
        logic [AW-1:2] hi_before;
        @(negedge clk);
        ld_ext_i = le; ld_alt_i = la; adv_n_i = an; addr_i = a;
        hi_before = addr_o[AW-1:2];
        @(posedge clk);
        if (le || la) begin
            m_base = a; m_cnt = 2'd0;
        end else if (!an) begin
            m_cnt = m_cnt + 2'd1;
        end
        #1;
        check(req, expect_addr());
        if (!(le || la)) begin
            n_vec++;
            if (addr_o[AW-1:2] !== hi_before) begin
                n_bad++;
                $display("FAIL R3: upper=%h expected=%h", addr_o[AW-1:2], hi_before);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", '0);

        for (int m = 0; m < 2; m++) begin
            mode_i = m[0];
            for (int s = 0; s < 4; s++) begin
                a = {6'(8'h2B + s * 13 + m * 7), 2'(s)};
                // R9: alternate which strobe starts the burst
                if (s[0]) cycle(1'b0, 1'b1, 1'b1, a, "R9");
                else      cycle(1'b1, 1'b0, 1'b1, a, "R2");
                for (int k = 0; k < 6; k++) begin
                    cycle(1'b0, 1'b0, 1'b0, 8'hFF, m ? "R4" : "R5");
                    if (k == 3) check("R7", a);
                    if (k == 1 || k == 4) cycle(1'b0, 1'b0, 1'b1, 8'h00, "R6");
                end
                // R8: a load colliding with an advance restarts at the new base
                a = a ^ 8'hC3;
                cycle(1'b1, 1'b0, 1'b0, a, "R8");
                check("R8", a);
                cycle(1'b0, 1'b0, 1'b0, 8'h00, m ? "R4" : "R5");
                cycle(1'b1, 1'b1, 1'b1, ~a, "R9");
                cycle(1'b0, 1'b0, 1'b1, a, "R6");
            end
        end

        // Known sequences quoted in the requirements
        mode_i = 1'b1;
        cycle(1'b1, 1'b0, 1'b1, 8'h41, "R4");
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R4"); check("R4", 8'h40);
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R4"); check("R4", 8'h43);
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R4"); check("R4", 8'h42);
        mode_i = 1'b0;
        cycle(1'b0, 1'b1, 1'b1, 8'h92, "R5");
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R5"); check("R5", 8'h93);
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R5"); check("R5", 8'h90);
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R5"); check("R5", 8'h91);
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R7"); check("R7", 8'h92);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule